// File: doc/BRIEF.md
# Serial NOR Boot Reader with Bus-Width Probe

This block is the boot-time master for a serial NOR flash. After `start` it opens a first transaction at a slow serial clock, issues a plain single-line read of a fixed header location, and collects a four-byte reply. If that reply carries the expected width-detection signature, the block closes the transaction, waits a guard interval with chip select high, and opens a second transaction that reads the image over all four data lines at a faster clock. If the signature is wrong, the image is read over single lines at the slow clock instead, and the `mismatch` flag tells the rest of the chip.

Image bytes leave on a valid/ready byte stream. When the consumer holds back, the serial clock is frozen in place, so no byte is ever lost or overwritten. The read stops after the programmed byte count. `done` rises once the last byte has been taken, and it stays high until the next `start`.

Top module: `qspi_boot_reader`

## Requirements
- R1: The first transaction drives the 32-bit word 0x03000020 (read command 0x03, then header address 0x000020), MSB first, on io_out[0] with io_oe = 4'b0001. Bits change after a falling SCLK edge and are stable at each rising edge.
- R2: The 4 probe reply bytes are taken MSB first from io_in[1] only, on the rising edges that follow the 32 command/address bits. The block enables quad reading only if the bytes arrive as 0x66, 0x55, 0x99, 0xAA in that order.
- R3: On any other probe reply, mismatch goes high and the image is read with command 0x03 plus start_addr on a single line: bits on io_in[1], no dummy cycles, slow clock.
- R4: The probe, and any fallback read, runs with an SCLK half-period of SLOW_HALF clk cycles (default 12). A quad image read runs with a half-period of 2^clk_div_sel clk cycles.
- R5: A quad image transaction sends {0x6B, start_addr[23:0]} MSB first on io_out[0].
- R6: In quad mode, exactly 8 SCLK cycles pass after the address bits. Each byte is then sampled from io_in[3:0] as two nibbles, high nibble first.
- R7: io_oe is only ever 4'b0000 or 4'b0001. It is nonzero only while cs_n is low in the command/address phase, so no line is driven during dummy or data phases.
- R8: Every transaction opens with a falling edge on cs_n. SCLK is low whenever cs_n is high and only rises while cs_n is low.
- R9: Between the probe transaction and the image transaction, cs_n stays high for at least 4*SLOW_HALF clk cycles (two slow SCLK periods).
- R10: Exactly byte_count image bytes appear on m_valid/m_data. While m_valid && !m_ready, m_data and SCLK hold steady.
- R11: done rises only after the last image byte has been accepted, and it stays high until a new start. With byte_count = 0, no image transaction takes place.
- R12: start is ignored while a read is in progress.
- R13: After reset: cs_n = 1, sclk = 0, io_oe = 0, done = 0, mismatch = 0, m_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin probe plus image read (idle or done only) |
| start_addr | input | 24 | Flash byte address of the image |
| byte_count | input | CNT_W | Number of image bytes to deliver |
| clk_div_sel | input | 2 | Fast half-period select, 2^sel clk cycles |
| done | output | 1 | Read complete, held until next start |
| mismatch | output | 1 | Probe signature failed, single-line fallback used |
| sclk | output | 1 | Serial clock to flash |
| cs_n | output | 1 | Flash chip select, active low |
| io_out | output | 4 | Serial data out, lane 0 used |
| io_oe | output | 4 | Per-line output enables |
| io_in | input | 4 | Serial data in from flash |
| m_valid | output | 1 | Image byte valid |
| m_data | output | 8 | Image byte |
| m_ready | input | 1 | Consumer accepts byte |

## Verification
Two events can fall in the same cycle: delivery of the final image byte, and the SCLK edge that would close the transaction. One bench vector holds m_ready low for forty cycles on the last byte, so the closing falling edge is frozen behind a pending byte. The bench judges this case by three things: done must never be seen together with m_valid, the byte count must be exact, and the delivered data must match the flash model. A second pairing, a start pulse that lands in the middle of a read, is judged by confirming that the byte stream and transaction count of the original request are unchanged.

// File: rtl/qbr_pkg.sv
package qbr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_DUMMY,
    ST_DATA,
    ST_TAIL,
    ST_GAP,
    ST_DONE
  } qbr_state_e;

  localparam logic [7:0]  OP_SINGLE_READ = 8'h03;
  localparam logic [7:0]  OP_QUAD_READ   = 8'h6B;
  localparam logic [23:0] HDR_ADDR       = 24'h000020;
  localparam logic [31:0] WIDTH_SIG      = 32'h665599AA;

  // fast SCLK half-period in clk cycles
  function automatic logic [3:0] fast_half(input logic [1:0] sel);
    return 4'(1) << sel;
  endfunction

  // index of the last sample within one byte
  function automatic logic [2:0] last_slot(input logic quad);
    return quad ? 3'd1 : 3'd7;
  endfunction

  function automatic logic [31:0] cmd_word(input logic quad, input logic [23:0] a);
    return {(quad ? OP_QUAD_READ : OP_SINGLE_READ), a};
  endfunction

endpackage

// File: rtl/qbr_sclk_gen.sv
module qbr_sclk_gen #(
  parameter int HW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          hold,
  input  logic [HW-1:0] half,
  output logic          sclk,
  output logic          rise_ev,
  output logic          fall_ev
);
  logic [HW-1:0] cnt;
  logic          wrap;

  assign wrap    = run && !hold && (cnt == half - HW'(1));
  assign rise_ev = wrap && !sclk;
  assign fall_ev = wrap && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!hold) begin
      if (wrap) begin
        cnt  <= '0;
        sclk <= ~sclk;
      end else begin
        cnt <= cnt + HW'(1);
      end
    end
  end
endmodule

// File: rtl/qbr_rx_shift.sv
module qbr_rx_shift
  import qbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       sample,
  input  logic       quad,
  input  logic [3:0] io_in,
  output logic       byte_done,
  output logic [7:0] byte_val
);
  logic [7:0] sr;
  logic [2:0] slot;

  assign byte_val  = quad ? {sr[3:0], io_in} : {sr[6:0], io_in[1]};
  assign byte_done = sample && (slot == last_slot(quad));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      slot <= '0;
    end else if (clr) begin
      sr   <= '0;
      slot <= '0;
    end else if (sample) begin
      sr   <= byte_val;
      slot <= byte_done ? 3'd0 : slot + 3'd1;
    end
  end
endmodule

// File: rtl/qspi_boot_reader.sv
module qspi_boot_reader
  import qbr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SLOW_HALF   = 12,
  parameter int GAP_PERIODS = 2,
  parameter int DUMMY_CYC   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [23:0]      start_addr,
  input  logic [CNT_W-1:0] byte_count,
  input  logic [1:0]       clk_div_sel,
  output logic             done,
  output logic             mismatch,
  output logic             sclk,
  output logic             cs_n,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  input  logic [3:0]       io_in,
  output logic             m_valid,
  output logic [7:0]       m_data,
  input  logic             m_ready
);
  localparam int HW      = $clog2((SLOW_HALF > 8 ? SLOW_HALF : 8) + 1);
  localparam int EMAX    = DUMMY_CYC > 32 ? DUMMY_CYC : 32;
  localparam int EW      = $clog2(EMAX + 1);
  localparam int GAP_CYC = GAP_PERIODS * 2 * SLOW_HALF;
  localparam int GW      = $clog2(GAP_CYC + 1);

  qbr_state_e       state;
  logic             img_txn, quad_q, mismatch_q;
  logic [HW-1:0]    fast_q, half_now;
  logic [31:0]      tx_sr, probe_sr;
  logic [EW-1:0]    ecnt;
  logic [GW-1:0]    gap_cnt;
  logic [CNT_W-1:0] left, cnt_q;
  logic [23:0]      addr_q;
  logic             m_valid_q;
  logic [7:0]       m_data_q;

  // named internal events
  logic run_w, hold_w, rise_ev, fall_ev, quad_now;
  logic byte_done, rx_clr, accept_start, load_image;
  logic img_txn_w, quiet_w;
  logic [7:0] rx_byte;

  assign quad_now     = img_txn && quad_q;
  assign run_w        = (state == ST_CMD) || (state == ST_DUMMY) ||
                        (state == ST_DATA) || (state == ST_TAIL);
  assign hold_w       = m_valid_q && !m_ready;
  assign half_now     = quad_now ? fast_q : HW'(SLOW_HALF);
  assign accept_start = start && ((state == ST_IDLE) || (state == ST_DONE));
  assign load_image   = (state == ST_GAP) && !img_txn &&
                        (gap_cnt == GW'(GAP_CYC - 1)) && (cnt_q != '0);
  assign rx_clr       = accept_start || load_image;
  assign img_txn_w    = img_txn;
  assign quiet_w      = (state == ST_DUMMY) || (state == ST_DATA) || (state == ST_TAIL);

  qbr_sclk_gen #(.HW(HW)) u_clk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_w),
    .hold   (hold_w),
    .half   (half_now),
    .sclk   (sclk),
    .rise_ev(rise_ev),
    .fall_ev(fall_ev)
  );

  qbr_rx_shift u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (rx_clr),
    .sample   (rise_ev && (state == ST_DATA)),
    .quad     (quad_now),
    .io_in    (io_in),
    .byte_done(byte_done),
    .byte_val (rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      img_txn    <= 1'b0;
      quad_q     <= 1'b0;
      mismatch_q <= 1'b0;
      fast_q     <= '0;
      tx_sr      <= '0;
      probe_sr   <= '0;
      ecnt       <= '0;
      gap_cnt    <= '0;
      left       <= '0;
      cnt_q      <= '0;
      addr_q     <= '0;
      m_valid_q  <= 1'b0;
      m_data_q   <= '0;
    end else begin
      if (m_valid_q && m_ready) m_valid_q <= 1'b0;
      case (state)
        ST_IDLE, ST_DONE: begin
          if (accept_start) begin
            tx_sr      <= cmd_word(1'b0, HDR_ADDR);
            img_txn    <= 1'b0;
            quad_q     <= 1'b0;
            mismatch_q <= 1'b0;
            fast_q     <= HW'(fast_half(clk_div_sel));
            addr_q     <= start_addr;
            cnt_q      <= byte_count;
            left       <= CNT_W'(4);
            ecnt       <= '0;
            state      <= ST_CMD;
          end
        end
        ST_CMD: begin
          if (rise_ev) ecnt <= ecnt + EW'(1);
          if (fall_ev) begin
            if (ecnt == EW'(32)) begin
              ecnt  <= '0;
              state <= quad_now ? ST_DUMMY : ST_DATA;
            end else begin
              tx_sr <= {tx_sr[30:0], 1'b0};
            end
          end
        end
        ST_DUMMY: begin
          if (rise_ev) ecnt <= ecnt + EW'(1);
          if (fall_ev && (ecnt == EW'(DUMMY_CYC))) state <= ST_DATA;
        end
        ST_DATA: begin
          if (byte_done) begin
            left <= left - CNT_W'(1);
            if (img_txn) begin
              m_valid_q <= 1'b1;
              m_data_q  <= rx_byte;
            end else begin
              probe_sr <= {probe_sr[23:0], rx_byte};
            end
            if (left == CNT_W'(1)) state <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (fall_ev) begin
            state   <= ST_GAP;
            gap_cnt <= '0;
            if (!img_txn) begin
              quad_q     <= (probe_sr == WIDTH_SIG);
              mismatch_q <= (probe_sr != WIDTH_SIG);
            end
          end
        end
        ST_GAP: begin
          if (gap_cnt != GW'(GAP_CYC - 1)) begin
            gap_cnt <= gap_cnt + GW'(1);
          end else if (!img_txn) begin
            if (load_image) begin
              img_txn <= 1'b1;
              tx_sr   <= cmd_word(quad_q, addr_q);
              left    <= cnt_q;
              ecnt    <= '0;
              state   <= ST_CMD;
            end else begin
              state <= ST_DONE;
            end
          end else if (!m_valid_q) begin
            state <= ST_DONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cs_n     = !run_w;
  assign io_oe    = (state == ST_CMD) ? 4'b0001 : 4'b0000;
  assign io_out   = {3'b000, (state == ST_CMD) && tx_sr[31]};
  assign done     = (state == ST_DONE);
  assign mismatch = mismatch_q;
  assign m_valid  = m_valid_q;
  assign m_data   = m_data_q;

endmodule

// File: rtl/qbr_checker.sv
module qbr_checker #(
  parameter int GAP_CYC = 48
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sclk,
  input logic [3:0] io_oe,
  input logic       m_valid,
  input logic       m_ready,
  input logic [7:0] m_data,
  input logic       done,
  input logic       img_txn_w,
  input logic       quiet_w
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= '0;
    else if (!cs_n) hi_cnt <= '0;
    else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
  end

  assert_oe_lane0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe[3:1] == 3'b000) && ((io_oe != 4'b0000) -> !cs_n));

  assert_quiet_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_w |-> (io_oe == 4'b0000));

  assert_sclk_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_sclk_rise_in_txn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> !cs_n);

  assert_cs_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(cs_n) && img_txn_w) |-> (hi_cnt >= 16'(GAP_CYC)));

  assert_byte_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  assert_sclk_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> $stable(sclk));

  assert_done_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !m_valid));
endmodule

bind qspi_boot_reader qbr_checker #(.GAP_CYC(GAP_PERIODS * 2 * SLOW_HALF)) u_qbr_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .sclk     (sclk),
  .io_oe    (io_oe),
  .m_valid  (m_valid),
  .m_ready  (m_ready),
  .m_data   (m_data),
  .done     (done),
  .img_txn_w(img_txn_w),
  .quiet_w  (quiet_w)
);

// File: tb/test_qspi_boot_reader.sv
module test_qspi_boot_reader;
  localparam int SLOW = 12;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [23:0] start_addr = '0;
  logic [15:0] byte_count = '0;
  logic [1:0]  clk_div_sel = '0;
  logic        done, mismatch, sclk, cs_n, m_valid, m_ready;
  logic [3:0]  io_out, io_oe;
  logic [3:0]  flash_io = 4'b0000;
  logic [7:0]  m_data;

  always #4 clk = ~clk;

  qspi_boot_reader i_qspi_boot_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .clk_div_sel(clk_div_sel), .done(done),
    .mismatch(mismatch), .sclk(sclk), .cs_n(cs_n), .io_out(io_out),
    .io_oe(io_oe), .io_in(flash_io), .m_valid(m_valid), .m_data(m_data),
    .m_ready(m_ready)
  );

  int n_tests = 0, n_fail = 0;
  logic bad_probe = 1'b0;

  // flash content model: signature at the header, computed pattern elsewhere
  function automatic logic [7:0] fbyte(input logic [23:0] a, input logic bad);
    logic [7:0] m;
    m = a[7:0] * 8'd13;
    case (a)
      24'h20:  return 8'h66;
      24'h21:  return 8'h55;
      24'h22:  return bad ? 8'h98 : 8'h99;
      24'h23:  return 8'hAA;
      default: return m ^ a[15:8] ^ 8'h3C;
    endcase
  endfunction

  // ---------------- flash responder ----------------
  int txn_seq = 0;
  int seen_seq = 0;
  int r = 0;
  logic [31:0] cw = '0;
  logic [31:0] txn_cmd [0:63];
  int txn_half [0:63];
  int gap_log [0:63];

  always @(negedge cs_n) txn_seq = txn_seq + 1;

  always @(posedge sclk) begin
    if (!cs_n) begin
      if (seen_seq != txn_seq) begin seen_seq = txn_seq; r = 0; cw = '0; end
      if (r < 32) cw = {cw[30:0], io_out[0]};
      r = r + 1;
      if (r == 32 && txn_seq > 0 && txn_seq <= 64) txn_cmd[txn_seq-1] = cw;
    end
  end

  always @(negedge sclk) begin
    if (!cs_n) begin
      if (cw[31:24] == 8'h03 && r >= 32) begin
        int idx;
        logic [7:0] b;
        idx = r - 32;
        b = fbyte(cw[23:0] + 24'(idx / 8), bad_probe);
        flash_io <= {2'b00, b[7 - (idx % 8)], 1'b0};
      end else if (cw[31:24] == 8'h6B && r >= 40) begin
        int n;
        logic [7:0] b;
        n = r - 40;
        b = fbyte(cw[23:0] + 24'(n / 2), bad_probe);
        flash_io <= (n % 2 == 0) ? b[7:4] : b[3:0];
      end
    end
  end

  // ---------------- consumer and monitors ----------------
  int rmode = 0, exp_n = 0, rx_base = 0, rx_n = 0, stall_c = 0, cyc = 0;
  int hl = 0, gc = 0;
  logic [7:0] rx_buf [0:255];
  bit early_done = 0, oe_bad = 0, sclk_bad = 0;

  always @(negedge clk) begin
    bit rdy;
    cyc = cyc + 1;
    case (rmode)
      0: rdy = 1'b1;
      1: rdy = (cyc % 3 == 0);
      default: begin
        rdy = ((rx_n - rx_base) != exp_n - 1) || (stall_c >= 40);
        if (m_valid && (rx_n - rx_base) == exp_n - 1) stall_c = stall_c + 1;
      end
    endcase
    m_ready = rdy;
    if (rst_n && m_valid && m_ready) begin
      if (rx_n < 256) rx_buf[rx_n] = m_data;
      rx_n = rx_n + 1;
      stall_c = 0;
    end
    if (rst_n && done && m_valid) early_done = 1;
    if (rst_n && (io_oe[3:1] != 3'b000 || (io_oe != 4'b0000 && cs_n))) oe_bad = 1;
    if (rst_n && cs_n && sclk) sclk_bad = 1;
    // min SCLK high time per transaction
    if (sclk) hl = hl + 1;
    else if (hl != 0) begin
      if (txn_seq > 0 && txn_seq <= 64 && hl < txn_half[txn_seq-1]) txn_half[txn_seq-1] = hl;
      hl = 0;
    end
    // cs_n high time before each transaction
    if (cs_n) gc = gc + 1;
    else if (gc != 0) begin
      if (txn_seq > 0 && txn_seq <= 64) begin
        gap_log[txn_seq-1] = gc;
        txn_half[txn_seq-1] = 1000000;
      end
      gc = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic pulse_start(input logic [23:0] a, input int n, input logic [1:0] sel);
    @(negedge clk);
    start_addr  = a;
    byte_count  = 16'(n);
    clk_div_sel = sel;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 40000) begin @(negedge clk); t++; end
  endtask

  task automatic check_bytes(input logic [23:0] a, input int n, input string tag);
    int errs = 0;
    logic [7:0] fa = '0, fe = '0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      e = fbyte(a + 24'(i), bad_probe);
      if (rx_buf[rx_base + i] !== e) begin
        if (errs == 0) begin fa = rx_buf[rx_base + i]; fe = e; end
        errs++;
      end
    end
    chk(errs == 0, tag, fa, fe);
  endtask

  task automatic run_vec(input logic [23:0] a, input int n, input logic [1:0] sel,
                         input logic bad, input int rm);
    int tb0;
    int exp_half;
    bad_probe = bad;
    rmode = rm;
    exp_n = n;
    tb0 = txn_seq;
    rx_base = rx_n;
    pulse_start(a, n, sel);
    wait_done();
    chk(done === 1'b1, "R11 done after read", done, 1);
    chk(txn_seq - tb0 == 2, "R11 two transactions", txn_seq - tb0, 2);
    chk(txn_cmd[tb0] == 32'h03000020, "R1 probe command word", txn_cmd[tb0], 32'h03000020);
    chk(txn_half[tb0] == SLOW, "R4 probe half-period", txn_half[tb0], SLOW);
    chk(mismatch === bad, "R2 R3 mismatch flag", mismatch, bad);
    if (bad) begin
      chk(txn_cmd[tb0+1] == {8'h03, a}, "R3 fallback command word", txn_cmd[tb0+1], {8'h03, a});
      exp_half = SLOW;
    end else begin
      chk(txn_cmd[tb0+1] == {8'h6B, a}, "R5 quad command word", txn_cmd[tb0+1], {8'h6B, a});
      exp_half = 1 << sel;
    end
    chk(txn_half[tb0+1] == exp_half, "R4 image half-period", txn_half[tb0+1], exp_half);
    chk(gap_log[tb0+1] >= 4 * SLOW, "R9 chip-select gap", gap_log[tb0+1], 4 * SLOW);
    chk(rx_n - rx_base == n, "R10 byte count", rx_n - rx_base, n);
    check_bytes(a, n, bad ? "R3 fallback data" : "R6 quad data");
  endtask

  // {addr, count, sel, bad, ready_mode}
  localparam logic [44:0] VEC [6] = '{
    {24'h001000, 16'd16, 2'd0, 1'b0, 2'd0},
    {24'h0003F0, 16'd9,  2'd1, 1'b0, 2'd1},
    {24'h123456, 16'd20, 2'd3, 1'b0, 2'd2},
    {24'h000100, 16'd6,  2'd2, 1'b1, 2'd0},
    {24'h00001E, 16'd8,  2'd0, 1'b0, 2'd1},
    {24'hFFFFFC, 16'd4,  2'd2, 1'b0, 2'd2}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(cs_n === 1'b1 && sclk === 1'b0, "R13 bus idle in reset", {cs_n, sclk}, 2'b10);
    chk(io_oe === 4'b0000, "R13 no drive in reset", io_oe, 0);
    chk(done === 1'b0 && mismatch === 1'b0 && m_valid === 1'b0, "R13 flags clear",
        {done, mismatch, m_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      logic [44:0] e;
      e = VEC[v];
      run_vec(e[44:21], int'(e[20:5]), e[4:3], e[2], int'(e[1:0]));
    end

    // R11 zero byte count: probe only, no image transaction
    begin
      int tb0;
      bad_probe = 1'b0; rmode = 0; tb0 = txn_seq; rx_base = rx_n;
      pulse_start(24'h000400, 0, 2'd1);
      wait_done();
      chk(done === 1'b1, "R11 done with zero count", done, 1);
      chk(txn_seq - tb0 == 1, "R11 no image transaction", txn_seq - tb0, 1);
      chk(rx_n - rx_base == 0, "R11 no bytes", rx_n - rx_base, 0);
    end

    // R12 start while busy is ignored
    begin
      int tb0;
      bad_probe = 1'b0; rmode = 1; exp_n = 10; tb0 = txn_seq; rx_base = rx_n;
      pulse_start(24'h002000, 10, 2'd1);
      repeat (900) @(negedge clk);
      chk(done === 1'b0, "R12 still busy", done, 0);
      pulse_start(24'h00ABCD, 3, 2'd0);
      wait_done();
      chk(txn_seq - tb0 == 2, "R12 transaction count unchanged", txn_seq - tb0, 2);
      chk(rx_n - rx_base == 10, "R12 byte count unchanged", rx_n - rx_base, 10);
      check_bytes(24'h002000, 10, "R12 data of original request");
    end

    chk(early_done == 0, "R11 done never with pending byte", early_done, 0);
    chk(oe_bad == 0, "R7 output enables", oe_bad, 0);
    chk(sclk_bad == 0, "R8 sclk low while deselected", sclk_bad, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R11 watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule